// File: doc/BRIEF.md
# Dual-Strobe Control Bus Interface

This block is the slave side of a small microprocessor-style control port. An address bus, a write-data bus and a read-data bus with an output enable serve a compact register file. A set of general-purpose registers sits at the bottom of the address space. A mode register at address 12 holds sign-format and power-control bits. The core uses the general registers in ways this block does not define.

One set of strobe pins serves two conventions. The read-enable pin doubles as a strap. If it is held low, the block runs the legacy convention: the write-enable pin acts as a read/write select (high means read) and the chip-enable pin acts as the chip select. Otherwise the three pins are separate active-low read, write and chip enables, as on a memory device. All strobes pass through a two-flop synchronizer into the core clock, and all edges are detected after it. The mode is re-evaluated only while chip enable is inactive, so it cannot change during an access.

Four bits of the mode register flip the most significant bit of four sample words. Two words sit on the input stream toward the core and two on the result stream leaving it. Flipping the MSB converts offset binary to two's complement and back. Both streams pass through with no storage and follow valid/ready rules: a word moves when valid and ready are both high in the same cycle. `in_ready` follows `core_ready` and `res_ready` follows `out_ready` in the same cycle, so back-pressure reaches upstream with no delay. Software changes the inversion bits only while the streams are idle.

Top module: `dual_strobe_ctl`

## Requirements
- R1: With the strap (`re_strap_n`) held low, the legacy convention applies. `we_n` high means read and `we_n` low means write, and `ce_n` is the chip select.
- R2: With the strap high, the memory convention applies, with separate active-low `re_strap_n`, `we_n` and `ce_n`. General registers 0..NUM_GP-1 can be written and read back. Register k appears on `gp_regs[8k+7:8k]`.
- R3: In legacy mode, a write is captured when `ce_n` rises while `we_n` is low. A select cycle with `we_n` high writes nothing.
- R4: In memory mode, a write is captured when `we_n` rises while `ce_n` is low. A `we_n` pulse with `ce_n` high writes nothing.
- R5: `bus_oe` is high only while the chip is selected for a read. In legacy mode that is `ce_n` low with `we_n` high. In memory mode it is `ce_n` low with `re_strap_n` low. While `bus_oe` is high, `bus_rdata` holds the addressed register.
- R6: The mode register is at address 12 with this layout: bit0 inverts the A input MSB, bit1 the B input MSB, bit2 the A result MSB, bit3 the B result MSB. Bit4 is the clock-detect disable and bit5 the force-power-down control. Only a write to address 12 changes it.
- R7: Reset clears the mode register and all general registers to 0 and deasserts `bus_oe`, so samples pass through unchanged.
- R8: When an inversion bit is set, only the MSB of its word is flipped. All lower bits pass through unchanged.
- R9: `clkdet_dis` and `force_pd` reflect mode bits 4 and 5. Bits 7:6 always read 0.
- R10: Addresses that are neither general registers nor 12 read as 0, and writes to them change nothing.
- R11: The streams pass through combinationally: `core_valid` = `in_valid`, `in_ready` = `core_ready`, `out_valid` = `res_valid` and `res_ready` = `out_ready`, all in the same cycle.
- R12: Each write strobe produces exactly one register update. The update takes effect only after the strobe's ending edge, within four clock cycles of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data from the bus |
| bus_rdata | output | 8 | Read data toward the bus |
| bus_oe | output | 1 | High while the bus must be driven |
| re_strap_n | input | 1 | Read enable; held low selects legacy mode |
| we_n | input | 1 | Write enable, or read/write select in legacy mode |
| ce_n | input | 1 | Chip enable / chip select |
| in_valid | input | 1 | Input stream valid |
| in_ready | output | 1 | Input stream ready |
| in_a | input | SAMP_W | Input word A |
| in_b | input | SAMP_W | Input word B |
| core_valid | output | 1 | Converted input valid |
| core_ready | input | 1 | Core ready for input |
| core_a | output | SAMP_W | Converted word A |
| core_b | output | SAMP_W | Converted word B |
| res_valid | input | 1 | Core result valid |
| res_ready | output | 1 | Core result ready |
| res_a | input | SAMP_W | Result word A from core |
| res_b | input | SAMP_W | Result word B from core |
| out_valid | output | 1 | Output stream valid |
| out_ready | input | 1 | Downstream ready |
| out_a | output | SAMP_W | Converted result A |
| out_b | output | SAMP_W | Converted result B |
| clkdet_dis | output | 1 | Clock-detect disable control |
| force_pd | output | 1 | Forced power-down control |
| gp_regs | output | NUM_GP*8 | General registers, register k in bits 8k+7:8k |

## Verification
The hardest case to reach is the moment a write lands. The update must not appear while the write strobe is still held, and it must appear within a few cycles after the strobe ends. The stimulus holds `we_n` low with a new power bit on the data bus and observes `clkdet_dis` while the strobe is still asserted. It then releases the strobe and observes the bit again a fixed number of cycles later. Switching the strap between conventions is reached by changing `re_strap_n` only while `ce_n` is high and letting the synchronizer settle. Legacy-mode select cycles are then run with `we_n` high, to show that they write nothing even when the data bus carries a different value.

// File: rtl/ctlbus_pkg.sv
`timescale 1ns/1ps
package ctlbus_pkg;
  localparam int REG_W   = 8;
  localparam int NM_ADDR = 12;

  typedef struct packed {
    logic [1:0] rsv;
    logic       force_pd;
    logic       clkdet_dis;
    logic       inv_bout;
    logic       inv_aout;
    logic       inv_bin;
    logic       inv_ain;
  } nm_t;
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [STAGES-1:0][N-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '1;
    else        pipe[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '1;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/access_decode.sv
`timescale 1ns/1ps
module access_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic re_s,
  input  logic we_s,
  input  logic ce_s,
  output logic legacy,
  output logic wr_hold,
  output logic wr_pulse,
  output logic drive
);
  logic ce_d, we_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d   <= 1'b1;
      we_d   <= 1'b1;
      legacy <= 1'b0;
    end else begin
      ce_d <= ce_s;
      we_d <= we_s;
      if (ce_s) legacy <= ~re_s;
    end
  end

  assign wr_hold  = ~ce_s & ~we_s;
  assign wr_pulse = legacy ? (~ce_d & ce_s & ~we_d)
                           : (~we_d & we_s & ~ce_d);
  assign drive    = ~ce_s & (legacy ? we_s : ~re_s);

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R12
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_s && !ce_d) |-> $stable(legacy)); // R1
endmodule

// File: rtl/reg_bank.sv
`timescale 1ns/1ps
module reg_bank
  import ctlbus_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_GP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_pulse,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [REG_W-1:0]        rd_data,
  output nm_t                     nm,
  output logic [NUM_GP*REG_W-1:0] gp_flat
);
  localparam logic [ADDR_W-1:0] NM_A = ADDR_W'(NM_ADDR);

  logic [NUM_GP-1:0][REG_W-1:0] gp;
  logic [REG_W-1:0]             rd_next;

  for (genvar k = 0; k < NUM_GP; k++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       gp[k] <= '0;
      else if (wr_pulse && wr_addr == ADDR_W'(k))       gp[k] <= wr_data;
    end
    assign gp_flat[k*REG_W +: REG_W] = gp[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           nm <= '0;
    else if (wr_pulse && wr_addr == NM_A) nm <= nm_t'({2'b00, wr_data[5:0]});
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == NM_A) rd_next = nm;
    for (int k = 0; k < NUM_GP; k++)
      if (rd_addr == ADDR_W'(k)) rd_next = gp[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  AST_NM_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pulse && wr_addr == NM_A) |=> $stable(nm)); // R6
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= NUM_GP && rd_addr != NM_A) |=> rd_data == '0); // R10
endmodule

// File: rtl/msb_fix.sv
`timescale 1ns/1ps
module msb_fix #(
  parameter int W     = 16,
  parameter int LANES = 4
) (
  input  logic [LANES*W-1:0] din,
  input  logic [LANES-1:0]   inv,
  output logic [LANES*W-1:0] dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout[l*W +: W] = {din[l*W + W-1] ^ inv[l], din[l*W +: W-1]};
  end
endmodule

// File: rtl/dual_strobe_ctl.sv
`timescale 1ns/1ps
module dual_strobe_ctl
  import ctlbus_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NUM_GP      = 4,
  parameter int SAMP_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic                    bus_oe,
  input  logic                    re_strap_n,
  input  logic                    we_n,
  input  logic                    ce_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SAMP_W-1:0]       in_a,
  input  logic [SAMP_W-1:0]       in_b,
  output logic                    core_valid,
  input  logic                    core_ready,
  output logic [SAMP_W-1:0]       core_a,
  output logic [SAMP_W-1:0]       core_b,
  input  logic                    res_valid,
  output logic                    res_ready,
  input  logic [SAMP_W-1:0]       res_a,
  input  logic [SAMP_W-1:0]       res_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [SAMP_W-1:0]       out_a,
  output logic [SAMP_W-1:0]       out_b,
  output logic                    clkdet_dis,
  output logic                    force_pd,
  output logic [NUM_GP*8-1:0]     gp_regs
);
  localparam int LANES = 4;

  logic [2:0]        strb_s;
  logic              re_s, we_s, ce_s;
  logic              legacy, wr_hold, wr_pulse, drive;
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0]        lat_data;
  nm_t               nm;
  logic [LANES*SAMP_W-1:0] lane_in, lane_out;

  strobe_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({re_strap_n, we_n, ce_n}),
    .sync_o(strb_s)
  );
  assign {re_s, we_s, ce_s} = strb_s;

  access_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .re_s(re_s), .we_s(we_s), .ce_s(ce_s),
    .legacy(legacy), .wr_hold(wr_hold), .wr_pulse(wr_pulse), .drive(drive)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_data <= '0;
    end else if (wr_hold) begin
      lat_addr <= bus_addr;
      lat_data <= bus_wdata;
    end
  end

  reg_bank #(.ADDR_W(ADDR_W), .NUM_GP(NUM_GP)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_pulse(wr_pulse), .wr_addr(lat_addr), .wr_data(lat_data),
    .rd_addr(bus_addr), .rd_data(bus_rdata),
    .nm(nm), .gp_flat(gp_regs)
  );

  assign bus_oe     = drive;
  assign clkdet_dis = nm.clkdet_dis;
  assign force_pd   = nm.force_pd;

  assign lane_in = {res_b, res_a, in_b, in_a};
  msb_fix #(.W(SAMP_W), .LANES(LANES)) u_fix (
    .din(lane_in),
    .inv({nm.inv_bout, nm.inv_aout, nm.inv_bin, nm.inv_ain}),
    .dout(lane_out)
  );
  assign {out_b, out_a, core_b, core_a} = lane_out;

  assign core_valid = in_valid;
  assign in_ready   = core_ready;
  assign out_valid  = res_valid;
  assign res_ready  = out_ready;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_s) && ce_s) |-> !bus_oe); // R5
endmodule

// File: tb/sim_dual_strobe_ctl.sv
`timescale 1ns/1ps
module sim_dual_strobe_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        bus_oe, re_n = 1'b1, we_n = 1'b1, ce_n = 1'b1;
  logic        in_valid = 0, in_ready, core_valid, core_ready = 0;
  logic [15:0] in_a = '0, in_b = '0, core_a, core_b;
  logic        res_valid = 0, res_ready, out_valid, out_ready = 0;
  logic [15:0] res_a = '0, res_b = '0, out_a, out_b;
  logic        clkdet_dis, force_pd;
  logic [31:0] gp_regs;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       rd_ev;

  always #2 clk = ~clk;

  dual_strobe_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_oe(bus_oe), .re_strap_n(re_n), .we_n(we_n),
    .ce_n(ce_n), .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a),
    .in_b(in_b), .core_valid(core_valid), .core_ready(core_ready),
    .core_a(core_a), .core_b(core_b), .res_valid(res_valid),
    .res_ready(res_ready), .res_a(res_a), .res_b(res_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_a(out_a),
    .out_b(out_b), .clkdet_dis(clkdet_dis), .force_pd(force_pd),
    .gp_regs(gp_regs)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected read items and compares with the bus
  initial forever begin
    @(rd_ev);
    chk({tag_q.pop_front(), " oe"}, bus_oe, 1'b1);
    chk("R5 read data", bus_rdata, exp_q.pop_front());
  end

  task automatic push_read(logic [7:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> rd_ev;
  endtask

  task automatic mem_rd(logic [3:0] a, logic [7:0] e, string t);
    bus_addr = a; cyc(1);
    ce_n = 0; re_n = 0; cyc(6);
    push_read(e, t); cyc(1);
    re_n = 1; ce_n = 1; cyc(5);
  endtask

  task automatic mem_wr(logic [3:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; cyc(1);
    ce_n = 0; cyc(1); we_n = 0; cyc(5);
    we_n = 1; cyc(5); ce_n = 1; cyc(5);
  endtask

  task automatic leg_rd(logic [3:0] a, logic [7:0] e, string t);
    bus_addr = a; we_n = 1; cyc(1);
    ce_n = 0; cyc(6);
    push_read(e, t); cyc(1);
    ce_n = 1; cyc(5);
  endtask

  task automatic leg_wr(logic [3:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; we_n = 0; cyc(1);
    ce_n = 0; cyc(5);
    chk("R5 legacy write no drive", bus_oe, 1'b0);
    ce_n = 1; cyc(5); we_n = 1; cyc(5);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    in_a = 16'h8001; in_b = 16'h7FFF; res_a = 16'h1234; res_b = 16'h8000;
    cyc(5); rst_n = 1; cyc(5);
    // R7 reset state
    chk("R7 oe", bus_oe, 0);
    chk("R7 clkdet", clkdet_dis, 0);
    chk("R7 pd", force_pd, 0);
    chk("R7 core_a", core_a, 16'h8001);
    chk("R7 gp", gp_regs, 0);
    mem_rd(12, 8'h00, "R7 nm");
    // R9 / R6 memory-mode write of all ones
    mem_wr(12, 8'hFF);
    mem_rd(12, 8'h3F, "R9 nm rsv");
    chk("R9 clkdet", clkdet_dis, 1);
    chk("R9 pd", force_pd, 1);
    // R8 all lanes inverted
    chk("R8 core_a", core_a, 16'h0001);
    chk("R8 core_b", core_b, 16'hFFFF);
    chk("R8 out_a", out_a, 16'h9234);
    chk("R8 out_b", out_b, 16'h0000);
    // R6 layout: bit0 A in, bit2 A result
    mem_wr(12, 8'h05);
    chk("R6 core_a", core_a, 16'h0001);
    chk("R6 core_b", core_b, 16'h7FFF);
    chk("R6 out_a", out_a, 16'h9234);
    chk("R6 out_b", out_b, 16'h8000);
    chk("R6 clkdet", clkdet_dis, 0);
    // R2 general register
    mem_wr(1, 8'hA5);
    mem_rd(1, 8'hA5, "R2 gp1");
    chk("R2 gp_regs", gp_regs, 32'h0000A500);
    // R10 unimplemented
    mem_wr(7, 8'h77);
    mem_rd(7, 8'h00, "R10 addr7");
    mem_rd(15, 8'h00, "R10 addr15");
    mem_rd(12, 8'h05, "R10 nm intact");
    chk("R10 gp intact", gp_regs, 32'h0000A500);
    // R4 WE pulse without CE
    bus_addr = 2; bus_wdata = 8'h3C; cyc(1);
    we_n = 0; cyc(5); we_n = 1; cyc(5);
    mem_rd(2, 8'h00, "R4 no write");
    // R5 no drive during write, nor RE without CE
    bus_addr = 2; ce_n = 0; we_n = 0; cyc(6);
    chk("R5 mem write no drive", bus_oe, 0);
    we_n = 1; cyc(5); ce_n = 1; cyc(5);
    mem_rd(2, 8'h3C, "R4 write with CE");
    re_n = 0; cyc(6);
    chk("R5 RE without CE", bus_oe, 0);
    re_n = 1; cyc(5);
    // R12 update only after strobe end
    bus_addr = 12; bus_wdata = 8'h15; cyc(1);
    ce_n = 0; cyc(1); we_n = 0; cyc(6);
    chk("R12 held strobe", clkdet_dis, 0);
    we_n = 1; cyc(4);
    chk("R12 after edge", clkdet_dis, 1);
    ce_n = 1; cyc(5);
    mem_rd(12, 8'h15, "R12 single value");
    // R11 streams
    in_valid = 1; core_ready = 0; res_valid = 1; out_ready = 0; #1;
    chk("R11 core_valid", core_valid, 1);
    chk("R11 in_ready low", in_ready, 0);
    chk("R11 res_ready low", res_ready, 0);
    core_ready = 1; out_ready = 1; #1;
    chk("R11 in_ready", in_ready, 1);
    chk("R11 res_ready", res_ready, 1);
    chk("R11 out_valid", out_valid, 1);
    cyc(1);
    // R1 / R3 legacy mode via strap low
    re_n = 0; cyc(6);
    chk("R1 legacy idle no drive", bus_oe, 0);
    leg_wr(3, 8'h5A);
    leg_rd(3, 8'h5A, "R1 legacy read");
    bus_wdata = 8'hFF;
    leg_rd(3, 8'h5A, "R3 select with read does not write");
    leg_rd(3, 8'h5A, "R3 value kept");
    leg_wr(12, 8'h20);
    chk("R3 legacy pd", force_pd, 1);
    // R7 second reset
    rst_n = 0; re_n = 1; cyc(3); rst_n = 1; cyc(5);
    chk("R7 gp after reset", gp_regs, 0);
    mem_rd(12, 8'h00, "R7 nm after reset");
    cyc(2);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule